// File: doc/BRIEF.md
# Dual-Domain Petri Net Step Engine

This block executes a small Petri net in hardware, one step per clock cycle. Each place carries two independent fields. A token count belongs to the control side, and a data value belongs to the data side. Control transitions consume and produce tokens through pre-weight and post-weight vectors, and each may be gated by a guard that compares one place's data value with a configured label. Data transitions have no enabling rule of their own. They are tied to control transitions by link arcs, and they fire only in the same step as a control transition they are linked to. When a data transition fires, it forms a weighted sum of the data values and writes scaled copies of that sum into its output places.

A built-in scheduler resolves the choice among enabled control transitions. It takes a starting index from an 8-bit LFSR and then searches cyclically upward for the first enabled transition, so a run always makes the same choices. The whole net is given as static configuration vectors. The marking is loaded through a load strobe. The block reports the marking, the enabled vector, a deadlock flag, the index of the last fired transition and a one-cycle overflow flag.

Top module: `pnet_step_engine`

## Requirements
- R1: While rstN is low, and after it is released, every token count and data value is 0, fireValid and overflow are 0, and the LFSR holds 8'h01.
- R2: When loadEn is high at a clock edge, the marking becomes loadTok (each count limited to TOK_CAP) and loadVal on that edge, and fireValid is 0 afterwards. loadEn takes priority over stepEn, and the LFSR does not advance.
- R3: enabledVec[t] is 1 exactly when transition t's guard passes and every place p with a nonzero pre-weight holds at least that many tokens. A pre-weight of 0 imposes no condition. deadlock is 1 exactly when enabledVec is all zeros. Both outputs are combinational from the current marking.
- R4: When guardEn[t] is 0, transition t's guard passes. When guardEn[t] is 1, the guard passes only if the data value of place guardPlace[t*PIDX_W +: PIDX_W] equals guardLabel[t*DATA_W +: DATA_W].
- R5: On a step, the start index is (LFSR value) mod NUM_CTRL. The fired transition is the first enabled one found by going upward from the start index and wrapping around. Every step cycle, the LFSR advances to {s[6:0], s[7]^s[5]^s[4]^s[3]}, including steps taken in deadlock. The fired index appears on firedIdx after the edge, with fireValid set to 1.
- R6: When transition t fires, each place's count becomes old − pre + post. A count above TOK_CAP is held at TOK_CAP. Places with zero weights keep their counts.
- R7: Data transition d fires when linkArcs[d*NUM_CTRL+t] is 1 for the fired transition t. Its sum is Σ value[p]·inW[d][p], taken over the values from before the step. Each place with a nonzero outW[d][p] receives outW[d][p]·sum. Places with a zero output weight keep their values. If several data transitions write the same place, the highest-indexed one wins.
- R8: A data result above 2^DATA_W−1 is written as 2^DATA_W−1.
- R9: overflow is 1 for exactly the cycle after a step whose firing held a count at TOK_CAP or saturated a data result (R8). Otherwise it is 0.
- R10: A step taken while deadlock is 1 leaves the whole marking unchanged and leaves fireValid at 0.
- R11: A cycle with neither stepEn nor loadEn leaves the marking unchanged and clears fireValid and overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepEn | input | 1 | Execute one net step on this edge |
| loadEn | input | 1 | Load the marking from loadTok/loadVal |
| loadTok | input | NUM_PLACES*CNT_W | Counts to load; place p at [p*CNT_W +: CNT_W] |
| loadVal | input | NUM_PLACES*DATA_W | Values to load; place p at [p*DATA_W +: DATA_W] |
| preW | input | NUM_CTRL*NUM_PLACES*WGT_W | Pre-weight of transition t, place p, at [(t*NUM_PLACES+p)*WGT_W +: WGT_W] |
| postW | input | NUM_CTRL*NUM_PLACES*WGT_W | Post-weights, laid out like preW |
| guardEn | input | NUM_CTRL | Guard enable for each control transition |
| guardPlace | input | NUM_CTRL*PIDX_W | Place index compared by each guard |
| guardLabel | input | NUM_CTRL*DATA_W | Label compared by each guard |
| dataInW | input | NUM_DATA*NUM_PLACES*WGT_W | Input weight of data transition d, place p, at [(d*NUM_PLACES+p)*WGT_W +: WGT_W] |
| dataOutW | input | NUM_DATA*NUM_PLACES*WGT_W | Output weights, laid out like dataInW |
| linkArcs | input | NUM_DATA*NUM_CTRL | Bit d*NUM_CTRL+t links data transition d to control transition t |
| tokens | output | NUM_PLACES*CNT_W | Current token counts |
| values | output | NUM_PLACES*DATA_W | Current data values |
| enabledVec | output | NUM_CTRL | Enabled control transitions |
| deadlock | output | 1 | No control transition enabled |
| fireValid | output | 1 | A transition fired on the last edge |
| firedIdx | output | CIDX_W | Index of the last fired transition |
| overflow | output | 1 | Last firing hit a capacity limit |

## Verification
The bench keeps its own model of the net and sweeps thousands of steps. The marking is reloaded often, and the data value of the guard place is biased toward the guard label, so the guarded transitions switch between enabled and disabled. One directed case has a single enabled transition whose firing pushes a count past TOK_CAP: a design that wrapped the count instead of holding it would report 1 instead of 12 and leave overflow low. Another directed case has two data transitions writing the same place in one step. A design with the wrong write order would leave the saturated 255 where the later transition's 30 belongs. Deadlock steps are checked for a frozen marking, and the LFSR still advances on them: a design that stopped the LFSR in deadlock would choose different transitions from then on, and the sweep would show the mismatch.

// File: rtl/pnet_pkg.sv
package pnet_pkg;

  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic load;     // take the marking from the load inputs
    logic fire;     // commit the selected transition's firing
    logic advance;  // a step cycle occurred (LFSR moves)
  } pnStrobe_t;

  // 8-bit Fibonacci LFSR step used by the scheduler.
  function automatic logic [7:0] lfsrNext(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

endpackage

// File: rtl/pnet_ctrl.sv
module pnet_ctrl
  import pnet_pkg::*;
#(
  parameter int NUM_PLACES = 4,
  parameter int NUM_CTRL   = 4,
  parameter int NUM_DATA   = 2,
  parameter int WGT_W      = 2,
  parameter int CNT_W      = 4,
  parameter int DATA_W     = 8,
  parameter logic [7:0] LFSR_SEED = 8'h01,
  parameter int PIDX_W     = (NUM_PLACES > 1) ? $clog2(NUM_PLACES) : 1,
  parameter int CIDX_W     = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              stepEn,
  input  logic                              loadEn,
  input  logic [NUM_PLACES*CNT_W-1:0]       tokFlat,
  input  logic [NUM_PLACES*DATA_W-1:0]      valFlat,
  input  logic [NUM_CTRL*NUM_PLACES*WGT_W-1:0] preW,
  input  logic [NUM_CTRL-1:0]               guardEn,
  input  logic [NUM_CTRL*PIDX_W-1:0]        guardPlace,
  input  logic [NUM_CTRL*DATA_W-1:0]        guardLabel,
  input  logic [NUM_DATA*NUM_CTRL-1:0]      linkArcs,
  output logic [NUM_CTRL-1:0]               enabledVec,
  output logic                              deadlock,
  output pnStrobe_t                         strobe,
  output logic [CIDX_W-1:0]                 fireIdx,
  output logic [NUM_DATA-1:0]               dataFire
);

  // Enabling: token thresholds and optional equality guard per transition.
  for (genvar t = 0; t < NUM_CTRL; t++) begin : g_enable
    logic tokOk;
    logic guardOk;
    logic [PIDX_W-1:0] gPlace;

    assign gPlace = guardPlace[t*PIDX_W +: PIDX_W];

    always_comb begin
      tokOk = 1'b1;
      for (int p = 0; p < NUM_PLACES; p++) begin
        if (preW[(t*NUM_PLACES+p)*WGT_W +: WGT_W] != '0 &&
            int'(tokFlat[p*CNT_W +: CNT_W]) < int'(preW[(t*NUM_PLACES+p)*WGT_W +: WGT_W]))
          tokOk = 1'b0;
      end
    end

    assign guardOk = !guardEn[t] ||
                     (valFlat[int'(gPlace)*DATA_W +: DATA_W] == guardLabel[t*DATA_W +: DATA_W]);
    assign enabledVec[t] = tokOk && guardOk;
  end

  assign deadlock = ~|enabledVec;

  // Scheduler: LFSR-chosen start, cyclic upward search for an enabled one.
  logic [7:0] lfsr;
  int         startIdx;
  logic       found;

  always_comb begin
    startIdx = int'(lfsr) % NUM_CTRL;
    found    = 1'b0;
    fireIdx  = '0;
    for (int k = 0; k < NUM_CTRL; k++) begin
      if (!found && enabledVec[(startIdx + k) % NUM_CTRL]) begin
        found   = 1'b1;
        fireIdx = CIDX_W'((startIdx + k) % NUM_CTRL);
      end
    end
  end

  always_comb begin
    strobe.load    = loadEn;
    strobe.advance = stepEn && !loadEn;
    strobe.fire    = stepEn && !loadEn && found;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lfsr <= LFSR_SEED;
    else if (strobe.advance) lfsr <= lfsrNext(lfsr);
  end

  // Data transitions follow the fired control transition via link arcs.
  for (genvar d = 0; d < NUM_DATA; d++) begin : g_link
    assign dataFire[d] = strobe.fire && linkArcs[d*NUM_CTRL + int'(fireIdx)];
  end

endmodule

// File: rtl/pnet_datapath.sv
module pnet_datapath
  import pnet_pkg::*;
#(
  parameter int NUM_PLACES = 4,
  parameter int NUM_CTRL   = 4,
  parameter int NUM_DATA   = 2,
  parameter int WGT_W      = 2,
  parameter int CNT_W      = 4,
  parameter int TOK_CAP    = 12,
  parameter int DATA_W     = 8,
  parameter int CIDX_W     = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  pnStrobe_t                         strobe,
  input  logic [CIDX_W-1:0]                 fireIdx,
  input  logic [NUM_DATA-1:0]               dataFire,
  input  logic [NUM_CTRL*NUM_PLACES*WGT_W-1:0] preW,
  input  logic [NUM_CTRL*NUM_PLACES*WGT_W-1:0] postW,
  input  logic [NUM_DATA*NUM_PLACES*WGT_W-1:0] dataInW,
  input  logic [NUM_DATA*NUM_PLACES*WGT_W-1:0] dataOutW,
  input  logic [NUM_PLACES*CNT_W-1:0]       loadTok,
  input  logic [NUM_PLACES*DATA_W-1:0]      loadVal,
  output logic [NUM_PLACES*CNT_W-1:0]       tokFlat,
  output logic [NUM_PLACES*DATA_W-1:0]      valFlat,
  output logic                              fireValid,
  output logic [CIDX_W-1:0]                 firedIdx,
  output logic                              overflow
);

  localparam int TOKX_W = CNT_W + 2;
  localparam int SUM_W  = DATA_W + WGT_W + $clog2(NUM_PLACES) + 1;
  localparam int PROD_W = SUM_W + WGT_W;
  localparam logic [DATA_W-1:0] DATA_MAX = '1;

  logic [CNT_W-1:0]  tok      [NUM_PLACES];
  logic [DATA_W-1:0] val      [NUM_PLACES];
  logic [CNT_W-1:0]  tokNext  [NUM_PLACES];
  logic [CNT_W-1:0]  tokLoad  [NUM_PLACES];
  logic [DATA_W-1:0] valNext  [NUM_PLACES];
  logic [NUM_PLACES-1:0] tokOv;
  logic [SUM_W-1:0]  dSum     [NUM_DATA];
  logic              dataOv;

  // Token update with saturation at TOK_CAP, one lane per place.
  for (genvar p = 0; p < NUM_PLACES; p++) begin : g_tok
    logic [TOKX_W-1:0] raw;
    logic [TOKX_W-1:0] ldExt;
    assign raw = TOKX_W'(tok[p])
               - TOKX_W'(preW[(int'(fireIdx)*NUM_PLACES+p)*WGT_W +: WGT_W])
               + TOKX_W'(postW[(int'(fireIdx)*NUM_PLACES+p)*WGT_W +: WGT_W]);
    assign tokOv[p]   = raw > TOKX_W'(TOK_CAP);
    assign tokNext[p] = tokOv[p] ? CNT_W'(TOK_CAP) : CNT_W'(raw);
    assign ldExt      = TOKX_W'(loadTok[p*CNT_W +: CNT_W]);
    assign tokLoad[p] = (ldExt > TOKX_W'(TOK_CAP)) ? CNT_W'(TOK_CAP) : CNT_W'(ldExt);
    assign tokFlat[p*CNT_W +: CNT_W]   = tok[p];
    assign valFlat[p*DATA_W +: DATA_W] = val[p];
  end

  // Weighted input sum of each data transition over pre-step values.
  for (genvar d = 0; d < NUM_DATA; d++) begin : g_sum
    always_comb begin
      dSum[d] = '0;
      for (int p = 0; p < NUM_PLACES; p++)
        dSum[d] = dSum[d] + SUM_W'(val[p]) *
                  SUM_W'(dataInW[(d*NUM_PLACES+p)*WGT_W +: WGT_W]);
    end
  end

  // Output writes; later (higher-indexed) data transitions override.
  logic [PROD_W-1:0] prod;
  logic [WGT_W-1:0]  wOut;
  always_comb begin
    dataOv = 1'b0;
    prod   = '0;
    wOut   = '0;
    for (int p = 0; p < NUM_PLACES; p++) valNext[p] = val[p];
    for (int d = 0; d < NUM_DATA; d++) begin
      for (int p = 0; p < NUM_PLACES; p++) begin
        wOut = dataOutW[(d*NUM_PLACES+p)*WGT_W +: WGT_W];
        prod = PROD_W'(dSum[d]) * PROD_W'(wOut);
        if (dataFire[d] && wOut != '0) begin
          if (prod > PROD_W'(DATA_MAX)) begin
            valNext[p] = DATA_MAX;
            dataOv     = 1'b1;
          end else begin
            valNext[p] = DATA_W'(prod);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PLACES; p++) begin
        tok[p] <= '0;
        val[p] <= '0;
      end
      fireValid <= 1'b0;
      firedIdx  <= '0;
      overflow  <= 1'b0;
    end else if (strobe.load) begin
      for (int p = 0; p < NUM_PLACES; p++) begin
        tok[p] <= tokLoad[p];
        val[p] <= loadVal[p*DATA_W +: DATA_W];
      end
      fireValid <= 1'b0;
      overflow  <= 1'b0;
    end else if (strobe.fire) begin
      for (int p = 0; p < NUM_PLACES; p++) begin
        tok[p] <= tokNext[p];
        val[p] <= valNext[p];
      end
      fireValid <= 1'b1;
      firedIdx  <= fireIdx;
      overflow  <= (|tokOv) || dataOv;
    end else begin
      fireValid <= 1'b0;
      overflow  <= 1'b0;
    end
  end

endmodule

// File: rtl/pnet_step_engine.sv
module pnet_step_engine
  import pnet_pkg::*;
#(
  parameter int NUM_PLACES = 4,
  parameter int NUM_CTRL   = 4,
  parameter int NUM_DATA   = 2,
  parameter int WGT_W      = 2,
  parameter int CNT_W      = 4,
  parameter int TOK_CAP    = 12,
  parameter int DATA_W     = 8,
  parameter logic [7:0] LFSR_SEED = 8'h01,
  parameter int PIDX_W     = (NUM_PLACES > 1) ? $clog2(NUM_PLACES) : 1,
  parameter int CIDX_W     = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 stepEn,
  input  logic                                 loadEn,
  input  logic [NUM_PLACES*CNT_W-1:0]          loadTok,
  input  logic [NUM_PLACES*DATA_W-1:0]         loadVal,
  input  logic [NUM_CTRL*NUM_PLACES*WGT_W-1:0] preW,
  input  logic [NUM_CTRL*NUM_PLACES*WGT_W-1:0] postW,
  input  logic [NUM_CTRL-1:0]                  guardEn,
  input  logic [NUM_CTRL*PIDX_W-1:0]           guardPlace,
  input  logic [NUM_CTRL*DATA_W-1:0]           guardLabel,
  input  logic [NUM_DATA*NUM_PLACES*WGT_W-1:0] dataInW,
  input  logic [NUM_DATA*NUM_PLACES*WGT_W-1:0] dataOutW,
  input  logic [NUM_DATA*NUM_CTRL-1:0]         linkArcs,
  output logic [NUM_PLACES*CNT_W-1:0]          tokens,
  output logic [NUM_PLACES*DATA_W-1:0]         values,
  output logic [NUM_CTRL-1:0]                  enabledVec,
  output logic                                 deadlock,
  output logic                                 fireValid,
  output logic [CIDX_W-1:0]                    firedIdx,
  output logic                                 overflow
);

  pnStrobe_t           strobe;
  logic [CIDX_W-1:0]   fireIdx;
  logic [NUM_DATA-1:0] dataFire;

  pnet_ctrl #(
    .NUM_PLACES(NUM_PLACES), .NUM_CTRL(NUM_CTRL), .NUM_DATA(NUM_DATA),
    .WGT_W(WGT_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .LFSR_SEED(LFSR_SEED),
    .PIDX_W(PIDX_W), .CIDX_W(CIDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .loadEn(loadEn),
    .tokFlat(tokens), .valFlat(values), .preW(preW),
    .guardEn(guardEn), .guardPlace(guardPlace), .guardLabel(guardLabel),
    .linkArcs(linkArcs), .enabledVec(enabledVec), .deadlock(deadlock),
    .strobe(strobe), .fireIdx(fireIdx), .dataFire(dataFire)
  );

  pnet_datapath #(
    .NUM_PLACES(NUM_PLACES), .NUM_CTRL(NUM_CTRL), .NUM_DATA(NUM_DATA),
    .WGT_W(WGT_W), .CNT_W(CNT_W), .TOK_CAP(TOK_CAP), .DATA_W(DATA_W),
    .CIDX_W(CIDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fireIdx(fireIdx),
    .dataFire(dataFire), .preW(preW), .postW(postW),
    .dataInW(dataInW), .dataOutW(dataOutW),
    .loadTok(loadTok), .loadVal(loadVal),
    .tokFlat(tokens), .valFlat(values),
    .fireValid(fireValid), .firedIdx(firedIdx), .overflow(overflow)
  );

endmodule

// File: rtl/pnet_step_engine_chk.sv
module pnet_step_engine_chk #(
  parameter int NUM_PLACES = 4,
  parameter int NUM_CTRL   = 4,
  parameter int CNT_W      = 4,
  parameter int TOK_CAP    = 12,
  parameter int DATA_W     = 8,
  parameter int CIDX_W     = 2
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          stepEn,
  input logic                          loadEn,
  input logic [NUM_PLACES*DATA_W-1:0]  loadVal,
  input logic [NUM_PLACES*CNT_W-1:0]   tokens,
  input logic [NUM_PLACES*DATA_W-1:0]  values,
  input logic [NUM_CTRL-1:0]           enabledVec,
  input logic                          deadlock,
  input logic                          fireValid,
  input logic [CIDX_W-1:0]             firedIdx,
  input logic                          overflow
);

  logic [NUM_CTRL-1:0] enPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= '0;
    else       enPrev <= enabledVec;
  end

  AST_LOAD_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (values == $past(loadVal)) && !fireValid); // R2

  AST_FIRED_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    fireValid |-> enPrev[firedIdx]); // R5

  AST_STEP_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !loadEn && !deadlock) |=> fireValid); // R5

  AST_DEADLOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !loadEn && deadlock) |=> (!fireValid && $stable(tokens) && $stable(values))); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !loadEn) |=> (!fireValid && !overflow && $stable(tokens) && $stable(values))); // R11

  AST_OVF_WITH_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> fireValid); // R9

  for (genvar p = 0; p < NUM_PLACES; p++) begin : g_cap
    AST_TOK_CAP: assert property (@(posedge clk) disable iff (!rstN)
      int'(tokens[p*CNT_W +: CNT_W]) <= TOK_CAP); // R6
  end

endmodule

bind pnet_step_engine pnet_step_engine_chk #(
  .NUM_PLACES(NUM_PLACES), .NUM_CTRL(NUM_CTRL), .CNT_W(CNT_W),
  .TOK_CAP(TOK_CAP), .DATA_W(DATA_W), .CIDX_W(CIDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .stepEn(stepEn), .loadEn(loadEn),
  .loadVal(loadVal), .tokens(tokens), .values(values),
  .enabledVec(enabledVec), .deadlock(deadlock), .fireValid(fireValid),
  .firedIdx(firedIdx), .overflow(overflow)
);

// File: tb/pnet_step_engine_bench.sv
module pnet_step_engine_bench;

  localparam int NP = 4, NC = 4, ND = 2, WW = 2, CW = 4, CAP = 12, DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepEn = 1'b0, loadEn = 1'b0;
  logic [NP*CW-1:0]    loadTok = '0;
  logic [NP*DW-1:0]    loadVal = '0;
  logic [NC*NP*WW-1:0] preW = '0, postW = '0;
  logic [NC-1:0]       guardEn = '0;
  logic [NC*2-1:0]     guardPlace = '0;
  logic [NC*DW-1:0]    guardLabel = '0;
  logic [ND*NP*WW-1:0] dataInW = '0, dataOutW = '0;
  logic [ND*NC-1:0]    linkArcs = '0;
  logic [NP*CW-1:0]    tokens;
  logic [NP*DW-1:0]    values;
  logic [NC-1:0]       enabledVec;
  logic                deadlock, fireValid, overflow;
  logic [1:0]          firedIdx;

  always #5 clk = ~clk;

  pnet_step_engine u_pnet_step_engine (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .loadEn(loadEn),
    .loadTok(loadTok), .loadVal(loadVal), .preW(preW), .postW(postW),
    .guardEn(guardEn), .guardPlace(guardPlace), .guardLabel(guardLabel),
    .dataInW(dataInW), .dataOutW(dataOutW), .linkArcs(linkArcs),
    .tokens(tokens), .values(values), .enabledVec(enabledVec),
    .deadlock(deadlock), .fireValid(fireValid), .firedIdx(firedIdx),
    .overflow(overflow)
  );

  // Net configuration
  int pre  [NC][NP] = '{'{3,2,0,1}, '{0,0,1,0}, '{0,3,0,0}, '{0,0,0,2}};
  int post [NC][NP] = '{'{0,1,2,0}, '{1,0,0,1}, '{2,0,0,3}, '{0,0,1,0}};
  int gEn  [NC] = '{0,1,1,0};
  int gPl  [NC] = '{0,3,0,0};
  int gLb  [NC] = '{0,5,0,0};
  int win  [ND][NP] = '{'{1,0,0,2}, '{0,1,1,0}};
  int wout [ND][NP] = '{'{0,3,0,0}, '{0,1,0,1}};
  int link [ND][NC] = '{'{1,0,1,0}, '{1,1,0,1}};

  // Model state
  int mTok[NP], mVal[NP];
  logic [7:0] mLfsr;
  bit mFv, mOvf;
  int mIdx;

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit mEn(int t);
    if (gEn[t] != 0 && mVal[gPl[t]] != gLb[t]) return 1'b0;
    for (int p = 0; p < NP; p++)
      if (pre[t][p] != 0 && mTok[p] < pre[t][p]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic modelStep();
    int start, pick;
    int nT[NP], nV[NP];
    start = int'(mLfsr) % NC;
    pick = -1;
    for (int k = 0; k < NC; k++)
      if (pick < 0 && mEn((start + k) % NC)) pick = (start + k) % NC;
    mLfsr = {mLfsr[6:0], mLfsr[7] ^ mLfsr[5] ^ mLfsr[4] ^ mLfsr[3]};
    mFv = 1'b0; mOvf = 1'b0;
    if (pick < 0) return;
    mFv = 1'b1; mIdx = pick;
    for (int p = 0; p < NP; p++) begin
      nT[p] = mTok[p] - pre[pick][p] + post[pick][p];
      if (nT[p] > CAP) begin nT[p] = CAP; mOvf = 1'b1; end
      nV[p] = mVal[p];
    end
    for (int d = 0; d < ND; d++) begin
      if (link[d][pick] != 0) begin
        int s = 0;
        for (int p = 0; p < NP; p++) s += mVal[p] * win[d][p];
        for (int p = 0; p < NP; p++) begin
          if (wout[d][p] != 0) begin
            nV[p] = wout[d][p] * s;
            if (nV[p] > 255) begin nV[p] = 255; mOvf = 1'b1; end
          end
        end
      end
    end
    mTok = nT; mVal = nV;
  endtask

  task automatic checkEnabled(input string req);
    logic [NC-1:0] e;
    for (int t = 0; t < NC; t++) e[t] = mEn(t);
    chk(enabledVec == e, req, "enabledVec", enabledVec, e);
    chk(deadlock == (e == '0), "R3", "deadlock", deadlock, (e == '0));
  endtask

  task automatic checkState(input string ctx);
    for (int p = 0; p < NP; p++) begin
      chk(int'(tokens[p*CW +: CW]) == mTok[p], "R6", {ctx, " tokens"},
          tokens[p*CW +: CW], mTok[p]);
      chk(int'(values[p*DW +: DW]) == mVal[p], "R7 R8", {ctx, " values"},
          values[p*DW +: DW], mVal[p]);
    end
    chk(fireValid == mFv, "R5", {ctx, " fireValid"}, fireValid, mFv);
    if (mFv) chk(int'(firedIdx) == mIdx, "R5", {ctx, " firedIdx"}, firedIdx, mIdx);
    chk(overflow == mOvf, "R9", {ctx, " overflow"}, overflow, mOvf);
  endtask

  // One operation, started and checked at a falling edge.
  task automatic doOp(input bit st, input bit ld, input int lt[NP], input int lv[NP],
                      input string ctx);
    checkEnabled("R3 R4");
    stepEn = st; loadEn = ld;
    for (int p = 0; p < NP; p++) begin
      loadTok[p*CW +: CW] = CW'(lt[p]);
      loadVal[p*DW +: DW] = DW'(lv[p]);
    end
    @(posedge clk);
    @(negedge clk);
    stepEn = 1'b0; loadEn = 1'b0;
    if (ld) begin
      for (int p = 0; p < NP; p++) begin
        mTok[p] = (lt[p] > CAP) ? CAP : lt[p];
        mVal[p] = lv[p];
      end
      mFv = 1'b0; mOvf = 1'b0;
    end else if (st) begin
      modelStep();
    end else begin
      mFv = 1'b0; mOvf = 1'b0;
    end
    checkState(ctx);
  endtask

  initial begin
    int z[NP] = '{0,0,0,0};
    for (int t = 0; t < NC; t++) begin
      for (int p = 0; p < NP; p++) begin
        preW[(t*NP+p)*WW +: WW]  = WW'(pre[t][p]);
        postW[(t*NP+p)*WW +: WW] = WW'(post[t][p]);
      end
      guardEn[t] = gEn[t][0];
      guardPlace[t*2 +: 2] = 2'(gPl[t]);
      guardLabel[t*DW +: DW] = DW'(gLb[t]);
    end
    for (int d = 0; d < ND; d++) begin
      for (int p = 0; p < NP; p++) begin
        dataInW[(d*NP+p)*WW +: WW]  = WW'(win[d][p]);
        dataOutW[(d*NP+p)*WW +: WW] = WW'(wout[d][p]);
      end
      for (int t = 0; t < NC; t++) linkArcs[d*NC+t] = link[d][t][0];
    end
    mTok = z; mVal = z; mLfsr = 8'h01; mFv = 0; mOvf = 0; mIdx = 0;

    repeat (3) @(negedge clk);
    chk(tokens == '0 && values == '0, "R1", "marking in reset", tokens, 0);
    chk(!fireValid && !overflow, "R1", "flags in reset", {fireValid, overflow}, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1 after reset");

    // R10: step in deadlock (all-zero marking), LFSR still advances
    doOp(1, 0, z, z, "R10 deadlock step");

    // R6: pre [3,2,0,1], post [0,1,2,0]; only t0 can fire
    doOp(0, 1, '{3,2,0,1}, z, "R2 load");
    doOp(1, 0, z, z, "R6 example");
    chk(tokens == {4'd0, 4'd2, 4'd1, 4'd0}, "R6", "example counts",
        tokens, {4'd0, 4'd2, 4'd1, 4'd0});

    // R4: guard on place 3 value == 5
    doOp(0, 1, '{0,0,1,0}, '{0,0,0,5}, "R4 load pass");
    chk(enabledVec[1] == 1'b1, "R4", "guard pass", enabledVec[1], 1);
    doOp(0, 1, '{0,0,1,0}, '{0,0,0,6}, "R4 load fail");
    chk(enabledVec == '0 && deadlock, "R4", "guard fail", enabledVec, 0);
    doOp(1, 0, z, z, "R10 guard deadlock");

    // R9: count 11+2 held at 12
    doOp(0, 1, '{3,2,11,1}, z, "R9 load");
    doOp(1, 0, z, z, "R9 token cap");
    chk(int'(tokens[2*CW +: CW]) == 12 && overflow, "R9", "count capped",
        tokens[2*CW +: CW], 12);

    // R7 R8: d0 saturates place 1, d1 (higher index) overrides it with 30
    doOp(0, 1, '{3,2,0,1}, '{200,10,20,100}, "R8 load");
    doOp(1, 0, z, z, "R8 data");
    chk(int'(values[1*DW +: DW]) == 30 && int'(values[3*DW +: DW]) == 30,
        "R7", "write order", values[1*DW +: DW], 30);
    chk(overflow == 1'b1, "R8", "data saturation flag", overflow, 1);

    // R11 idle, R2 load priority over step
    doOp(0, 0, z, z, "R11 idle");
    doOp(1, 1, '{1,1,1,1}, '{5,5,5,5}, "R2 load beats step");

    // Sweep
    for (int i = 0; i < 4000; i++) begin
      int lt[NP], lv[NP];
      int r = $urandom_range(0, 19);
      for (int p = 0; p < NP; p++) begin
        lt[p] = $urandom_range(0, 15);
        lv[p] = ($urandom_range(0, 1) != 0) ? $urandom_range(0, 9) : $urandom_range(0, 255);
      end
      if ($urandom_range(0, 1) != 0) lv[3] = 5;
      if (r < 3)       doOp(0, 1, lt, lv, "R2 sweep load");
      else if (r == 3) doOp(0, 0, lt, lv, "R11 sweep idle");
      else if (r == 4) doOp(1, 1, lt, lv, "R2 sweep load+step");
      else             doOp(1, 0, lt, lv, "R5 R6 R7 sweep step");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule